// File: doc/BRIEF.md
# Command-less Streaming Read Controller for a Serial Flash Target

This block sits on the target side of a serial flash bus and serves reads from a memory array through a synchronous read port. The bus is seen through single-cycle strobes already aligned to the system clock: `sck_rise` and `sck_fall` mark the serial clock edges, and `cs_n` is the chip select. Any two strobes are at least two system clocks apart, and the first rise strobe comes at least one cycle after `cs_n` falls. In the normal state each selection opens with an 8-bit command. A fast read (code 0x0B) is followed by a 24-bit address, a programmable run of dummy clocks and an endless byte stream.

In the command-less state a selection starts directly with the address. The level of DQ0 at the first dummy rise is a confirmation bit. In a command-less selection, 0 keeps the state for the next selection and 1 returns to the normal state. When `xip_enable` is set, a fast read whose confirmation bit is 0 enters the command-less state. A `rescue` input forces the next selection back to the normal state. Data leaves on 1, 2 or 4 lines, selected per selection, and the read address steps by one for each byte.

Top module: `xip_read_ctl`

## Requirements
- R1: After reset, `dq_oe` and `dq_out` are 0000, `mem_rd` is low, and the first selection expects a command.
- R2: In the normal state the first 8 rise strobes carry a command on DQ0, MSB first. Only 0x0B continues. With any other code the block enables no output and issues no memory read until `cs_n` rises.
- R3: The address is 24 bits, MSB first. `lane_sel` 00 or 11 takes 1 bit per rise on DQ0. 01 takes 2 bits, with DQ1 as the higher bit. 10 takes 4 bits, with DQ3 as the highest bit. `lane_sel` and `dummy_cfg` are captured when `cs_n` falls.
- R4: The dummy phase lasts `dummy_cfg` rise strobes, and 0 means 15. Outputs stay disabled until the fall strobe that follows the last dummy rise, which carries the first data beat.
- R5: Each fall strobe in the data phase presents the next bits of the current byte, MSB first. One line uses DQ1 with `dq_oe`=0010. Two lines use DQ1:DQ0 (DQ1 higher) with 0011. Four lines use DQ3:DQ0 with 1111.
- R6: The byte address advances by one per byte and wraps from 0xFFFFFF to 0x000000.
- R7: In a command-less selection, DQ0 at the first dummy rise decides the next selection: 0 keeps it command-less, 1 makes it expect a command.
- R8: A normal fast read enters the command-less state for the next selection only if `xip_enable` is 1 and its confirmation bit is 0. Otherwise the normal state stays.
- R9: In a command-less selection, the first rise strobes after `cs_n` falls carry the address directly, with no command.
- R10: One cycle after `cs_n` is high, `dq_oe` and `dq_out` are 0000. A selection that ends before its confirmation bit leaves the stay-or-leave decision unchanged.
- R11: `rescue` high in any cycle makes the next selection expect a command. It wins over a confirmation bit sampled in the same cycle.
- R12: `mem_rd` pulses for one cycle when the address completes and once per byte started, so a stream of N bytes issues N+1 reads. Read data is taken from the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, synchronous |
| sck_rise | input | 1 | One-cycle strobe for a serial clock rising edge |
| sck_fall | input | 1 | One-cycle strobe for a serial clock falling edge |
| dq_in | input | 4 | Data lines as driven by the host |
| lane_sel | input | 2 | Line count: 00/11 one, 01 two, 10 four |
| dummy_cfg | input | 4 | Dummy clock count, 0 meaning 15 |
| xip_enable | input | 1 | Volatile enable that allows entry to the command-less state |
| rescue | input | 1 | Forces the next selection to expect a command |
| dq_out | output | 4 | Data lines driven by the target |
| dq_oe | output | 4 | Per-line output enable |
| mem_rd | output | 1 | Read strobe of the array port |
| mem_addr | output | 24 | Read address of the array port |
| mem_rdata | input | 8 | Array data, valid the cycle after `mem_rd` |

## Verification
The rescue request and the confirmation sample can land in the same cycle. Both write the stay-or-leave decision, and they disagree when the confirmation bit asks to stay. The bench raises `rescue` together with the first dummy rise strobe of a command-less selection whose DQ0 is 0. It then opens a selection with a 0x0B command. Only a design in which the rescue won returns the expected bytes on the expected beats, so the scoreboard judges the outcome from the port data alone.

// File: rtl/xip_pkg.sv
package xip_pkg;

  typedef enum logic [2:0] {
    PH_OFF,
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_SKIP
  } phase_t;

  // number of data lines for a lane selection code
  function automatic logic [2:0] lane_num(input logic [1:0] sel);
    case (sel)
      2'b01:   return 3'd2;
      2'b10:   return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  // output enable pattern for a lane selection code
  function automatic logic [3:0] lane_oe(input logic [1:0] sel);
    case (sel)
      2'b01:   return 4'b0011;
      2'b10:   return 4'b1111;
      default: return 4'b0010;
    endcase
  endfunction

endpackage

// File: rtl/xip_mode_ctl.sv
module xip_mode_ctl (
  input  logic clk,
  input  logic rst,
  input  logic sel_start,
  input  logic confirm_en,
  input  logic confirm_bit,
  input  logic xip_enable,
  input  logic rescue,
  output logic stay_next
);

  logic in_session;

  always_ff @(posedge clk) begin
    if (rst) begin
      stay_next  <= 1'b0;
      in_session <= 1'b0;
    end else begin
      if (sel_start) in_session <= stay_next;
      if (rescue)
        stay_next <= 1'b0;
      else if (confirm_en)
        stay_next <= ~confirm_bit & (in_session | xip_enable);
    end
  end

  // R11: a rescue request always leaves the next selection in normal state
  a_r11_rescue_wins: assert property (@(posedge clk) disable iff (rst)
    rescue |=> !stay_next);

  // R7: a confirmation bit of 1 always leads out of the command-less state
  a_r7_leave: assert property (@(posedge clk) disable iff (rst)
    (confirm_en && confirm_bit) |=> !stay_next);

  // R8: without the enable, a normal selection cannot enter the mode
  a_r8_gate: assert property (@(posedge clk) disable iff (rst)
    (confirm_en && !in_session && !xip_enable) |=> !stay_next);

endmodule

// File: rtl/xip_addr_gen.sv
module xip_addr_gen #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        sel,
  input  logic [3:0]        bits,
  input  logic              acc_en,
  input  logic              launch,
  input  logic              advance,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr
);

  logic [ADDR_W-1:0] acc;
  logic [ADDR_W-1:0] asm_w;

  always_comb begin
    case (sel)
      2'b01:   asm_w = {acc[ADDR_W-3:0], bits[1:0]};
      2'b10:   asm_w = {acc[ADDR_W-5:0], bits};
      default: asm_w = {acc[ADDR_W-2:0], bits[0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      mem_addr <= '0;
      mem_rd   <= 1'b0;
    end else begin
      mem_rd <= 1'b0;
      if (acc_en) acc <= asm_w;
      if (launch) begin
        mem_addr <= asm_w;
        mem_rd   <= 1'b1;
      end else if (advance) begin
        mem_addr <= mem_addr + 1'b1;
        mem_rd   <= 1'b1;
      end
    end
  end

  // R12: each read request lasts exactly one cycle
  a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R6: a fetch for the following byte targets the next address, wrapping
  a_r6_step: assert property (@(posedge clk) disable iff (rst)
    (advance && !launch) |=> (mem_addr == $past(mem_addr) + 1'b1));

endmodule

// File: rtl/xip_out_ser.sv
module xip_out_ser
  import xip_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       shift_en,
  input  logic [1:0] sel,
  input  logic       rvalid,
  input  logic [7:0] rdata,
  output logic       byte_start,
  output logic [3:0] dq_out,
  output logic [3:0] dq_oe
);

  logic [7:0] nb;
  logic [7:0] sr;
  logic [2:0] beat;
  logic [2:0] beat_last;
  logic [7:0] val;

  always_comb begin
    case (sel)
      2'b01:   beat_last = 3'd3;
      2'b10:   beat_last = 3'd1;
      default: beat_last = 3'd7;
    endcase
  end

  assign byte_start = shift_en & (beat == 3'd0);
  assign val        = (beat == 3'd0) ? nb : sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      nb     <= '0;
      sr     <= '0;
      beat   <= '0;
      dq_out <= '0;
      dq_oe  <= '0;
    end else begin
      if (rvalid) nb <= rdata;
      if (clear) begin
        beat   <= '0;
        dq_out <= '0;
        dq_oe  <= '0;
      end else if (shift_en) begin
        case (sel)
          2'b01: begin
            dq_out <= {2'b00, val[7:6]};
            sr     <= {val[5:0], 2'b00};
          end
          2'b10: begin
            dq_out <= val[7:4];
            sr     <= {val[3:0], 4'b0000};
          end
          default: begin
            dq_out <= {2'b00, val[7], 1'b0};
            sr     <= {val[6:0], 1'b0};
          end
        endcase
        dq_oe <= lane_oe(sel);
        beat  <= (beat == beat_last) ? 3'd0 : beat + 3'd1;
      end
    end
  end

  // R5: only the three legal enable patterns, or none, are ever driven
  a_r5_oe_legal: assert property (@(posedge clk) disable iff (rst)
    (dq_oe == 4'b0000) || (dq_oe == 4'b0010) ||
    (dq_oe == 4'b0011) || (dq_oe == 4'b1111));

endmodule

// File: rtl/xip_read_ctl.sv
module xip_read_ctl
  import xip_pkg::*;
#(
  parameter int          ADDR_W     = 24,
  parameter int          DUMMY_W    = 4,
  parameter int          CMD_W      = 8,
  parameter logic [7:0]  FAST_RD_OP = 8'h0B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic [3:0]        dq_in,
  input  logic [1:0]        lane_sel,
  input  logic [3:0]        dummy_cfg,
  input  logic              xip_enable,
  input  logic              rescue,
  output logic [3:0]        dq_out,
  output logic [3:0]        dq_oe,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata
);

  localparam int CNT_W = $clog2(ADDR_W + 1);

  phase_t              phase;
  logic                cs_q;
  logic [CNT_W-1:0]    cnt;
  logic [CMD_W-1:0]    cmd_sr;
  logic [CMD_W-1:0]    cmd_next;
  logic [1:0]          sel_r;
  logic [DUMMY_W-1:0]  ndum_r;
  logic                rd_q;
  logic [CNT_W-1:0]    addr_last;
  logic [CNT_W-1:0]    dum_last;

  logic sel_start, acc_en, launch, confirm_en, shift_en, byte_start, stay_next;

  assign sel_start  = cs_q & ~cs_n;
  assign cmd_next   = {cmd_sr[CMD_W-2:0], dq_in[0]};
  assign dum_last   = CNT_W'(ndum_r) - CNT_W'(1);
  assign acc_en     = ~cs_n & sck_rise & (phase == PH_ADDR);
  assign launch     = acc_en & (cnt == addr_last);
  assign confirm_en = ~cs_n & sck_rise & (phase == PH_DUMMY) & (cnt == '0);
  assign shift_en   = ~cs_n & sck_fall & (phase == PH_DATA);

  always_comb begin
    case (sel_r)
      2'b01:   addr_last = CNT_W'(ADDR_W / 2 - 1);
      2'b10:   addr_last = CNT_W'(ADDR_W / 4 - 1);
      default: addr_last = CNT_W'(ADDR_W - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b1;
      phase  <= PH_OFF;
      cnt    <= '0;
      cmd_sr <= '0;
      sel_r  <= '0;
      ndum_r <= '1;
      rd_q   <= 1'b0;
    end else begin
      cs_q <= cs_n;
      rd_q <= mem_rd;
      if (cs_n) begin
        phase <= PH_OFF;
        cnt   <= '0;
      end else if (sel_start) begin
        phase  <= stay_next ? PH_ADDR : PH_CMD;
        cnt    <= '0;
        sel_r  <= lane_sel;
        ndum_r <= (dummy_cfg == '0) ? '1 : dummy_cfg;
      end else if (sck_rise) begin
        case (phase)
          PH_CMD: begin
            cmd_sr <= cmd_next;
            if (cnt == CNT_W'(CMD_W - 1)) begin
              cnt   <= '0;
              phase <= (cmd_next == FAST_RD_OP) ? PH_ADDR : PH_SKIP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_ADDR: begin
            if (cnt == addr_last) begin
              cnt   <= '0;
              phase <= PH_DUMMY;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_DUMMY: begin
            if (cnt == dum_last) begin
              cnt   <= '0;
              phase <= PH_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  xip_mode_ctl u_mode (
    .clk         (clk),
    .rst         (rst),
    .sel_start   (sel_start),
    .confirm_en  (confirm_en),
    .confirm_bit (dq_in[0]),
    .xip_enable  (xip_enable),
    .rescue      (rescue),
    .stay_next   (stay_next)
  );

  xip_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel_r),
    .bits     (dq_in),
    .acc_en   (acc_en),
    .launch   (launch),
    .advance  (byte_start),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr)
  );

  xip_out_ser u_ser (
    .clk        (clk),
    .rst        (rst),
    .clear      (cs_n),
    .shift_en   (shift_en),
    .sel        (sel_r),
    .rvalid     (rd_q),
    .rdata      (mem_rdata),
    .byte_start (byte_start),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe)
  );

  // R10: deselection releases the lines by the following cycle
  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (dq_oe == 4'b0000 && dq_out == 4'b0000));

  // R2: a rejected command neither drives nor reads
  a_r2_quiet: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP) |-> (dq_oe == 4'b0000 && !mem_rd));

  // R4: no line is driven while dummy clocks are still being counted
  a_r4_no_early_drive: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DUMMY) |-> (dq_oe == 4'b0000));

endmodule

// File: tb/xip_read_ctl_test.sv
module xip_read_ctl_test;

  typedef struct {
    logic [3:0] out;
    logic [3:0] oe;
    string      req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sck_rise = 1'b0;
  logic        sck_fall = 1'b0;
  logic [3:0]  dq_in = 4'h0;
  logic [1:0]  lane_sel = 2'b00;
  logic [3:0]  dummy_cfg = 4'd8;
  logic        xip_enable = 1'b0;
  logic        rescue = 1'b0;
  logic [3:0]  dq_out;
  logic [3:0]  dq_oe;
  logic        mem_rd;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;

  int  checks = 0;
  int  errors = 0;
  int  rd_cnt = 0;
  bit  done = 0;
  item_t q[$];
  event beat_ev;

  always #4 clk = ~clk;

  xip_read_ctl uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .dq_in(dq_in), .lane_sel(lane_sel), .dummy_cfg(dummy_cfg),
    .xip_enable(xip_enable), .rescue(rescue), .dq_out(dq_out), .dq_oe(dq_oe),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ 8'h3C;
  endfunction

  function automatic int nlanes(input logic [1:0] s);
    return (s == 2'b01) ? 2 : (s == 2'b10) ? 4 : 1;
  endfunction

  function automatic logic [3:0] oe_of(input logic [1:0] s);
    return (s == 2'b01) ? 4'b0011 : (s == 2'b10) ? 4'b1111 : 4'b0010;
  endfunction

  function automatic logic [3:0] beat_val(input logic [7:0] b, input int j, input int n);
    logic [7:0] s;
    s = b << (j * n);
    if (n == 1) return {2'b00, s[7], 1'b0};
    if (n == 2) return {2'b00, s[7:6]};
    return s[7:4];
  endfunction

  // synchronous array model, one cycle of read latency
  always @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);
  always @(posedge clk) if (!rst && mem_rd) rd_cnt = rd_cnt + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(beat_ev);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(dq_out == it.out && dq_oe == it.oe, it.req, "beat {oe,out}",
              {dq_oe, dq_out}, {it.oe, it.out});
      end
    end
  end

  // one serial clock: rise strobe, gap, fall strobe, then expectation
  task automatic sclk(input logic [3:0] din, input logic [3:0] eo,
                      input logic [3:0] eoe, input string req, input bit rsc);
    @(negedge clk); dq_in = din; sck_rise = 1'b1; rescue = rsc;
    @(negedge clk); sck_rise = 1'b0; rescue = 1'b0;
    @(negedge clk); sck_fall = 1'b1;
    @(negedge clk); sck_fall = 1'b0;
    q.push_back('{eo, eoe, req});
    -> beat_ev;
  endtask

  task automatic xfer(input bit with_cmd, input logic [7:0] cmd, input logic [23:0] addr,
                      input logic [1:0] sel, input logic [3:0] dcfg, input bit conf,
                      input int nbytes, input string req, input bit rsc_conf, input int abort_at);
    int  n, beats, nd, bpb, rd0;
    bit  acc, aborted;
    logic [3:0] eo, eoe;
    n = nlanes(sel); beats = 24 / n; bpb = 8 / n;
    nd = (dcfg == 4'd0) ? 15 : int'(dcfg);
    acc = !with_cmd || (cmd == 8'h0B);
    aborted = 0;
    rd0 = rd_cnt;
    lane_sel = sel; dummy_cfg = dcfg;
    @(negedge clk); cs_n = 1'b0;
    if (with_cmd)
      for (int i = 0; i < 8; i++) sclk({3'b000, cmd[7-i]}, 4'h0, 4'h0, req, 1'b0);
    for (int b = 0; b < beats; b++) begin
      logic [23:0] sh;
      if (b == abort_at) begin aborted = 1; break; end
      sh = addr >> (24 - n * (b + 1));
      sclk(4'(sh & 24'((1 << n) - 1)), 4'h0, 4'h0, req, 1'b0);
    end
    if (!aborted) begin
      for (int d = 0; d < nd; d++) begin
        eo = 4'h0; eoe = 4'h0;
        if (d == nd - 1 && acc) begin
          eo = beat_val(pat(addr), 0, n); eoe = oe_of(sel);
        end
        sclk((d == 0) ? {3'b000, conf} : 4'h0, eo, eoe, req, rsc_conf && d == 0);
      end
      for (int k = 1; k < nbytes * bpb; k++) begin
        eo = 4'h0; eoe = 4'h0;
        if (acc) begin
          eo  = beat_val(pat(addr + 24'(k / bpb)), k % bpb, n);
          eoe = oe_of(sel);
        end
        sclk(4'h0, eo, eoe, req, 1'b0);
      end
    end
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    check(dq_oe == 4'h0 && dq_out == 4'h0, "R10", "released {oe,out}",
          {dq_oe, dq_out}, 0);
    // R12: one read at address completion plus one per byte started
    check(rd_cnt - rd0 == ((acc && !aborted) ? nbytes + 1 : 0), "R12", "read count",
          rd_cnt - rd0, (acc && !aborted) ? nbytes + 1 : 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(dq_oe == 4'h0, "R1", "dq_oe after reset", dq_oe, 0);
    check(dq_out == 4'h0, "R1", "dq_out after reset", dq_out, 0);
    check(mem_rd == 1'b0, "R1", "mem_rd after reset", mem_rd, 0);

    // R1 R3 R4 R5: normal fast read on one line, confirm ignored without enable
    xfer(1, 8'h0B, 24'h001234, 2'b00, 4'd8, 1'b1, 3, "R5", 1'b0, -1);
    // R2: unknown command stays quiet through address, dummy and data clocks
    xfer(1, 8'h03, 24'h00ABCD, 2'b00, 4'd2, 1'b0, 2, "R2", 1'b0, -1);
    // R8: confirm 0 but enable low, next selection still needs a command
    xfer(1, 8'h0B, 24'h123456, 2'b01, 4'd4, 1'b0, 2, "R8", 1'b0, -1);
    xfer(1, 8'h0B, 24'h0F0F00, 2'b10, 4'd2, 1'b1, 2, "R8", 1'b0, -1);
    // R4 R8: entry with enable set, dummy code 0 gives 15 clocks, quad lines
    xip_enable = 1'b1;
    xfer(1, 8'h0B, 24'h400010, 2'b10, 4'd0, 1'b0, 2, "R4", 1'b0, -1);
    // R9 R6: command-less selection, two lines, address wraps past the top
    xfer(0, 8'h00, 24'hFFFFFE, 2'b01, 4'd3, 1'b0, 4, "R6", 1'b0, -1);
    // R10: abort during address keeps the decision to stay
    xfer(0, 8'h00, 24'h222222, 2'b00, 4'd5, 1'b0, 1, "R10", 1'b0, 10);
    // R7 R9: still command-less, confirm 1 leaves, dummy count of one
    xfer(0, 8'h00, 24'h00ABCD, 2'b10, 4'd1, 1'b1, 2, "R9", 1'b0, -1);
    // R7: normal state again, command required
    xfer(1, 8'h0B, 24'h345678, 2'b00, 4'd2, 1'b1, 1, "R7", 1'b0, -1);
    // R11: re-enter, then rescue coincides with a confirm of 0
    xfer(1, 8'h0B, 24'h777000, 2'b01, 4'd2, 1'b0, 1, "R11", 1'b0, -1);
    xfer(0, 8'h00, 24'h777100, 2'b01, 4'd2, 1'b0, 2, "R11", 1'b1, -1);
    xfer(1, 8'h0B, 24'h777200, 2'b10, 4'd3, 1'b1, 2, "R11", 1'b0, -1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule